// File: doc/BRIEF.md
# Packed BCD Byte Subtractor

This unit subtracts a packed decimal source byte and an incoming extend bit from a packed decimal destination byte. Each byte holds two decimal digits, one per nibble. A start strobe launches one operation. On the following clock edge the unit registers the decimal difference together with new extend, carry and zero flags, and it raises a done pulse for exactly one cycle.

The unit is built for multi-byte decimal subtraction. The controller presents the bytes least significant first. It feeds the previous extend output back as the next extend input and the previous zero output back as the next zero input. The zero flag is sticky. Any nonzero byte clears it, and a zero byte leaves it as it was. After the whole chain, the flag therefore says whether the complete multi-byte difference is zero. The controller starts the chain with the zero flag set.

The digit count is a parameter; the default of two digits gives a byte. Operand fetch and address handling belong to the surrounding datapath.

Top module: `bcd_byte_sub`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `diff_out`, `x_out`, `c_out`, `z_out` and `done` are all 0.
- R2: For operands whose nibbles are all in 0..9, `diff_out` is the packed BCD encoding of (dst − src − x_in) modulo 100. Bits [7:4] hold the tens digit and bits [3:0] hold the units digit.
- R3: `c_out` is 1 exactly when dst < src + x_in, comparing the bytes as unsigned integers.
- R4: `x_out` follows the same rule as `c_out`, so it is 1 exactly when the operation borrowed out of the top digit.
- R5: When the registered difference is nonzero, `z_out` is 0.
- R6: When the registered difference is 0x00, `z_out` equals the `z_in` that was sampled with the start strobe.
- R7: `done` is high in the cycle after each cycle in which `start` is high, and low otherwise. Starts on consecutive cycles give a done on each cycle.
- R8: In a cycle without `start`, the next clock edge leaves `diff_out`, `x_out`, `c_out` and `z_out` unchanged.
- R9: `n_out` and `v_out` are always 0.
- R10: Every digit, including non-decimal ones, follows one fixed rule. Compute t = a − b − borrow_in. If t is negative, the digit becomes (t − 6) mod 16 and a borrow passes to the next digit up. Otherwise the digit is t. The units digit takes `x_in` as its borrow_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch one subtraction this cycle |
| dst_byte | input | 8 | Packed BCD minuend |
| src_byte | input | 8 | Packed BCD subtrahend |
| x_in | input | 1 | Incoming extend (borrow) bit |
| z_in | input | 1 | Current zero flag of the chain |
| diff_out | output | 8 | Registered packed BCD difference |
| x_out | output | 1 | New extend bit |
| c_out | output | 1 | New carry (borrow) bit |
| z_out | output | 1 | New sticky zero flag |
| n_out | output | 1 | Negative flag, held at 0 |
| v_out | output | 1 | Overflow flag, held at 0 |
| done | output | 1 | One-cycle pulse after each start |

## Verification
Two things can happen in the same operation: the zero flag is kept and a final borrow is raised. A difference of exactly −100 wraps to 0x00 while also setting carry and extend. One example is 0x00 − 0x99 with `x_in` = 1; in that operation both digits correct by six and both borrow. The bench drives this case with `z_in` at both 0 and 1. Its model then requires `diff_out` = 0x00, `c_out` = `x_out` = 1 and an unchanged zero flag in the same done cycle. Multi-byte chains that feed outputs back as inputs also exercise this overlap as part of ordinary traffic.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DEC_FIX = 4'd6;

  typedef struct packed {
    logic [DIGIT_W-1:0] digit;
    logic               borrow;
  } digit_res_t;

  // One decimal digit of subtraction with borrow-in and six-correction.
  function automatic digit_res_t digit_sub(input logic [DIGIT_W-1:0] a,
                                           input logic [DIGIT_W-1:0] b,
                                           input logic               bin);
    digit_res_t         r;
    logic [DIGIT_W:0]   raw;
    raw      = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, bin};
    r.borrow = raw[DIGIT_W];
    r.digit  = raw[DIGIT_W] ? (raw[DIGIT_W-1:0] - DEC_FIX) : raw[DIGIT_W-1:0];
    return r;
  endfunction

  // Sticky zero: a nonzero result clears, a zero result keeps the old flag.
  function automatic logic sticky_zero(input logic is_zero, input logic z_prev);
    return is_zero ? z_prev : 1'b0;
  endfunction

endpackage

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub
  import bcd_sub_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  logic               borrow_in,
  output logic [DIGIT_W-1:0] d_dig,
  output logic               borrow_out
);
  digit_res_t res;

  always_comb begin
    res        = digit_sub(a_dig, b_dig, borrow_in);
    d_dig      = res.digit;
    borrow_out = res.borrow;
  end
endmodule

// File: rtl/bcd_borrow_chain.sv
module bcd_borrow_chain
  import bcd_sub_pkg::*;
#(
  parameter  int DIGITS = 2,
  localparam int W      = DIGITS * DIGIT_W
) (
  input  logic [W-1:0]    minuend,
  input  logic [W-1:0]    subtrahend,
  input  logic            ext_in,
  output logic [W-1:0]    diff,
  output logic [DIGITS:0] borrow_vec
);
  assign borrow_vec[0] = ext_in;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    bcd_digit_sub u_dig (
      .a_dig      (minuend   [i*DIGIT_W +: DIGIT_W]),
      .b_dig      (subtrahend[i*DIGIT_W +: DIGIT_W]),
      .borrow_in  (borrow_vec[i]),
      .d_dig      (diff      [i*DIGIT_W +: DIGIT_W]),
      .borrow_out (borrow_vec[i+1])
    );
  end
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit
  import bcd_sub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] diff,
  input  logic         top_borrow,
  input  logic         z_prev,
  output logic         res_zero,
  output logic         z_next,
  output logic         c_next,
  output logic         x_next
);
  always_comb begin
    res_zero = ~|diff;
    z_next   = sticky_zero(res_zero, z_prev);
    c_next   = top_borrow;
    x_next   = top_borrow;
  end
endmodule

// File: rtl/bcd_byte_sub.sv
module bcd_byte_sub
  import bcd_sub_pkg::*;
#(
  parameter  int DIGITS = 2,
  localparam int W      = DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dst_byte,
  input  logic [W-1:0] src_byte,
  input  logic         x_in,
  input  logic         z_in,
  output logic [W-1:0] diff_out,
  output logic         x_out,
  output logic         c_out,
  output logic         z_out,
  output logic         n_out,
  output logic         v_out,
  output logic         done
);
  // Named internal events, visible to the bound checker.
  logic [W-1:0]    diff_w;
  logic [DIGITS:0] chain_borrow;
  logic            top_borrow;
  logic            res_zero;
  logic            z_next, c_next, x_next;

  bcd_borrow_chain #(.DIGITS(DIGITS)) u_chain (
    .minuend    (dst_byte),
    .subtrahend (src_byte),
    .ext_in     (x_in),
    .diff       (diff_w),
    .borrow_vec (chain_borrow)
  );

  assign top_borrow = chain_borrow[DIGITS];

  bcd_flag_unit #(.W(W)) u_flags (
    .diff       (diff_w),
    .top_borrow (top_borrow),
    .z_prev     (z_in),
    .res_zero   (res_zero),
    .z_next     (z_next),
    .c_next     (c_next),
    .x_next     (x_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_out <= '0;
      x_out    <= 1'b0;
      c_out    <= 1'b0;
      z_out    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        diff_out <= diff_w;
        x_out    <= x_next;
        c_out    <= c_next;
        z_out    <= z_next;
      end
    end
  end

  // Flags left undefined by the operation are driven low for determinism.
  assign n_out = 1'b0;
  assign v_out = 1'b0;

endmodule

// File: rtl/bcd_byte_sub_chk.sv
module bcd_byte_sub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dst_byte,
  input logic [W-1:0] src_byte,
  input logic         x_in,
  input logic         z_in,
  input logic [W-1:0] diff_out,
  input logic         x_out,
  input logic         c_out,
  input logic         z_out,
  input logic         done
);
  function automatic logic all_dec(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < W/4; i++) begin
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done); // R7
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start)); // R7
  AST_CARRY_IS_BORROW: assert property (@(posedge clk) disable iff (rst)
    done |-> (c_out == ({1'b0, $past(dst_byte)} < ({1'b0, $past(src_byte)} + $past(x_in))))); // R3
  AST_EXTEND_IS_BORROW: assert property (@(posedge clk) disable iff (rst)
    done |-> (x_out == ({1'b0, $past(dst_byte)} < ({1'b0, $past(src_byte)} + $past(x_in))))); // R4
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done && (diff_out != '0)) |-> !z_out); // R5
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (done && (diff_out == '0)) |-> (z_out == $past(z_in))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(start) |-> ($stable(diff_out) && $stable(x_out) && $stable(c_out) && $stable(z_out))); // R8
  AST_DECIMAL_DIGITS: assert property (@(posedge clk) disable iff (rst)
    (done && all_dec($past(dst_byte)) && all_dec($past(src_byte))) |-> all_dec(diff_out)); // R2
endmodule

bind bcd_byte_sub bcd_byte_sub_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .dst_byte (dst_byte),
  .src_byte (src_byte),
  .x_in     (x_in),
  .z_in     (z_in),
  .diff_out (diff_out),
  .x_out    (x_out),
  .c_out    (c_out),
  .z_out    (z_out),
  .done     (done)
);

// File: tb/bcd_byte_sub_test.sv
module bcd_byte_sub_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] dst_byte = '0, src_byte = '0;
  logic       x_in = 1'b0, z_in = 1'b0;
  logic [7:0] diff_out;
  logic       x_out, c_out, z_out, n_out, v_out, done;

  int tests = 0;
  int fails = 0;

  bcd_byte_sub uut (
    .clk(clk), .rst(rst), .start(start),
    .dst_byte(dst_byte), .src_byte(src_byte), .x_in(x_in), .z_in(z_in),
    .diff_out(diff_out), .x_out(x_out), .c_out(c_out), .z_out(z_out),
    .n_out(n_out), .v_out(v_out), .done(done)
  );

  always #10 clk = ~clk; // 50 MHz

  // Behavioural reference: expected register state, advanced at each edge.
  int e_diff = 0, e_x = 0, e_c = 0, e_z = 0, e_done = 0;

  function automatic bit is_dec(int v);
    return ((v & 15) < 10) && ((v >> 4) < 10);
  endfunction

  // Returns {borrow, byte}
  function automatic int ref_sub(int d, int s, int x);
    int r, b, lo, hi, bl;
    if (is_dec(d) && is_dec(s)) begin
      r = ((d >> 4) * 10 + (d & 15)) - ((s >> 4) * 10 + (s & 15)) - x;
      b = (r < 0) ? 1 : 0;
      if (b) r += 100;
      return (b << 8) | ((r / 10) << 4) | (r % 10);
    end
    lo = (d & 15) - (s & 15) - x;
    bl = (lo < 0) ? 1 : 0;
    if (bl) lo = (lo + 32 - 6) & 15;
    hi = (d >> 4) - (s >> 4) - bl;
    b  = (hi < 0) ? 1 : 0;
    if (b) hi = (hi + 32 - 6) & 15;
    return (b << 8) | (hi << 4) | lo;
  endfunction

  always @(posedge clk) begin
    int r;
    if (rst) begin
      e_diff = 0; e_x = 0; e_c = 0; e_z = 0; e_done = 0;
    end else begin
      e_done = start;
      if (start) begin
        r      = ref_sub(dst_byte, src_byte, x_in);
        e_diff = r & 255;
        e_c    = r >> 8;
        e_x    = r >> 8;
        e_z    = (e_diff != 0) ? 0 : z_in;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R10 diff_out", diff_out, e_diff);
      chk("R3 c_out", c_out, e_c);
      chk("R4 x_out", x_out, e_x);
      chk("R5/R6 z_out", z_out, e_z);
      chk("R7 done", done, e_done);
      chk("R9 n_out/v_out", {n_out, v_out}, 0);
    end
  end

  task automatic op(input int d, input int s, input int x, input int z);
    @(negedge clk);
    start = 1'b1; dst_byte = d[7:0]; src_byte = s[7:0]; x_in = x[0]; z_in = z[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] hold_d;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset diff", diff_out, 0);
    chk("R1 reset flags", {x_out, c_out, z_out, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {diff_out, x_out, c_out, z_out, done}, 0);

    // R2/R3: basic subtractions
    op('h45, 'h23, 0, 1);           // 22, no borrow
    op('h00, 'h01, 0, 1);           // 99, borrow
    op('h50, 'h01, 1, 0);           // 48, low digit correction only
    op('h99, 'h99, 0, 1);           // 00, keep Z=1 (R6)
    op('h99, 'h99, 0, 0);           // 00, keep Z=0 (R6)
    op('h10, 'h09, 1, 1);           // 00 (R6)
    op('h37, 'h36, 0, 1);           // 01, Z cleared (R5)
    // Overlap: zero result together with final borrow (R3 R4 R6)
    op('h00, 'h99, 1, 1);
    op('h00, 'h99, 1, 0);

    // R8: outputs hold while idle, with inputs wiggled
    hold_d = diff_out;
    dst_byte = 'h12; src_byte = 'h34; x_in = 1; z_in = 0;
    idle(3);
    chk("R8 hold diff", diff_out, hold_d);

    // R7: back-to-back starts
    @(negedge clk);
    start = 1; dst_byte = 'h81; src_byte = 'h19; x_in = 0; z_in = 1;
    @(negedge clk);
    dst_byte = 'h05; src_byte = 'h07; x_in = 1;
    @(negedge clk);
    dst_byte = 'h42; src_byte = 'h42; x_in = 0;
    @(negedge clk);
    start = 0;
    idle(2);

    // R10: non-decimal digits
    op('h0A, 'h00, 0, 1);
    op('hF0, 'h0F, 0, 1);
    op('h3C, 'hAE, 1, 1);

    // Multi-byte chain: 4-byte 12345678 - 12345678 (zero) then 10000000 - 1
    begin
      int a[4] = '{'h78, 'h56, 'h34, 'h12};
      int b[4] = '{'h78, 'h56, 'h34, 'h12};
      int cx = 0, cz = 1;
      for (int i = 0; i < 4; i++) begin
        op(a[i], b[i], cx, cz);
        cx = x_out; cz = z_out;
      end
      chk("R6 chain zero", cz, 1);
      a = '{'h00, 'h00, 'h00, 'h10};
      b = '{'h01, 'h00, 'h00, 'h00};
      cx = 0; cz = 1;
      for (int i = 0; i < 4; i++) begin
        op(a[i], b[i], cx, cz);
        cx = x_out; cz = z_out;
      end
      chk("R5 chain nonzero", cz, 0);
      chk("R2 chain top byte", diff_out, 'h09);
      chk("R4 chain final extend", cx, 0);
    end

    // Random sweep, decimal and arbitrary operands
    for (int i = 0; i < 400; i++) begin
      int d, s;
      if (i % 2 == 0) begin
        d = ($urandom % 10) * 16 + ($urandom % 10);
        s = ($urandom % 10) * 16 + ($urandom % 10);
      end else begin
        d = $urandom % 256;
        s = $urandom % 256;
      end
      op(d, s, $urandom % 2, $urandom % 2);
      if (i % 7 == 0) idle(1);
    end

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule